// File: doc/BRIEF.md
# Accumulator CPU Core Sequencer

This block is a small 8-bit processor built around a single accumulator. It addresses 256 bytes of memory through one shared port. Every instruction is two bytes long: an opcode byte followed by one operand byte. A multi-cycle sequencer fetches both bytes. It reads a further byte when the instruction names its value indirectly, and then executes. A status word holds four flags in its low nibble. Its high nibble shows four sense-switch pins.

At reset the core takes its start address from the last byte of memory and begins fetching there. A wait input lets outside logic hold the core at an instruction boundary. A halt instruction stops all memory traffic until the next reset.

The accumulator, program counter, status word and halt state are brought out as ports, so a system can watch execution.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst` is high, both strobes are inactive (high), A, PC and the flags are 0, and `halted_o` is 0. In the first cycle after reset is released, the core reads address 0xFF, and PC holds that byte after the following clock edge.
- R2: The core reads the opcode at PC and then the operand at PC+1, each with a one-cycle read strobe. Immediate instructions (high nibble 0x5) and system instructions (high nibble 0x0) take 3 cycles. Indirect instructions (high nibble 0x6, low nibble 0-7) take 4 cycles, and their extra read is at the operand address.
- R3: Load (0x50 immediate, 0x60 indirect) puts the value into A. It sets Zero (status bit 1, 0x02) and Negative (bit 2, 0x04) from that value, and it keeps Carry.
- R4: Add (0x52/0x62) and subtract (0x53/0x63) work modulo 256. Carry (bit 0, 0x01) is the carry out for add and the borrow (A less than value) for subtract. Zero and Negative follow the result.
- R5: Store 0x51 writes A to the operand address. Store 0x61 writes A to the address read from the operand location. The write strobe is low for exactly one cycle and never at the same time as the read strobe.
- R6: Jump 0x54 loads PC with the operand. Jump 0x64 loads PC with the byte read at the operand address.
- R7: Skip-if-equal (0x55/0x65) adds 4 to PC when A equals the value and 2 otherwise. It leaves A and the flags unchanged.
- R8: Set-flag (0x56/0x66) ORs value bits 3:0 into the flags. Toggle-flag (0x57/0x67) XORs them in. Error is bit 3 (0x08).
- R9: Status bits 7:4 always show `sense_sw[3:0]`, with `sense_sw[3]` at 0x80. Set or toggle masks that aim at bits 7:4 have no effect.
- R10: Opcode 0x00, and every opcode not listed (for example 0x5C or 0x02), only adds 2 to PC and writes nothing.
- R11: Halt (0x01) adds 2 to PC and raises `halted_o`. After that there is no memory access until reset.
- R12: If `wait_n` is low at the end of an instruction or of the reset-vector read, no fetch starts. The opcode fetch begins in the cycle after `wait_n` is sampled high. An instruction already under way finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_sw | input | 4 | Sense-switch pins shown in status bits 7:4 |
| wait_n | input | 1 | Low pauses the core at the next instruction boundary |
| mem_rdata | input | 8 | Read data, valid in the cycle of the read strobe |
| mem_addr | output | 8 | Memory address |
| mem_wdata | output | 8 | Write data (the accumulator) |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 8 | Program counter |
| status_o | output | 8 | Sense switches in bits 7:4, flags E N Z C in bits 3:0 |
| halted_o | output | 1 | High once a halt has executed |

## Verification
After reset is released, PC holds the start address one clock edge later. A, PC and the flags take their new values at the last edge of each instruction: the third edge for immediate and system opcodes and the fourth for indirect ones. The bench derives that count from the opcode's high nibble, waits exactly that many rising edges, and samples on the falling edge that follows. Any error in cycle counting therefore shows up as a wrong A or PC. Wait behaviour is checked by counting edges while `wait_n` is held low and confirming that the read strobe stays high on each falling edge.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DW    = 8;
    localparam int AW    = 8;
    localparam int NFLAG = 4;

    // flag bit positions within the status low nibble
    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_N = 2;
    localparam int F_E = 3;

    // high-nibble group/mode selectors
    localparam logic [3:0] GRP_SYS = 4'h0;
    localparam logic [3:0] GRP_IMM = 4'h5;
    localparam logic [3:0] GRP_IND = 4'h6;

    localparam logic [AW-1:0] STEP_INSTR = AW'(2);
    localparam logic [AW-1:0] STEP_SKIP  = AW'(4);

    typedef enum logic [2:0] {
        ST_VEC,
        ST_FOP,
        ST_FARG,
        ST_IND,
        ST_EXE,
        ST_PAUSE,
        ST_HALT
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_LDA = 3'd0,
        OP_STA = 3'd1,
        OP_ADD = 3'd2,
        OP_SUB = 3'd3,
        OP_JMP = 3'd4,
        OP_SEQ = 3'd5,
        OP_SFL = 3'd6,
        OP_TGF = 3'd7
    } core_op_t;

    typedef enum logic [1:0] {
        K_NOP,
        K_HALT,
        K_IMM,
        K_IND
    } instr_kind_t;

    typedef struct packed {
        instr_kind_t kind;
        core_op_t    op;
    } decoded_t;

    function automatic decoded_t decode_byte(input logic [DW-1:0] b);
        decoded_t d;
        d.kind = K_NOP;
        d.op   = core_op_t'(b[2:0]);
        unique case (b[7:4])
            GRP_SYS: if (b[3:0] == 4'h1) d.kind = K_HALT;
            GRP_IMM: if (!b[3]) d.kind = K_IMM;
            GRP_IND: if (!b[3]) d.kind = K_IND;
            default: d.kind = K_NOP;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_cpu_pkg::*;
(
    input  logic [DW-1:0] opcode_i,
    output decoded_t      dec_o,
    output logic          needs_ind_o,
    output logic          is_store_o
);
    always_comb begin
        dec_o       = decode_byte(opcode_i);
        needs_ind_o = (dec_o.kind == K_IND);
        is_store_o  = ((dec_o.kind == K_IMM) || (dec_o.kind == K_IND))
                      && (dec_o.op == OP_STA);
    end
endmodule

// File: rtl/acc_addsub.sv
module acc_addsub
    import acc_cpu_pkg::*;
(
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  logic          sub_i,
    output logic [DW-1:0] res_o,
    output logic          carry_o,
    output logic          zero_o,
    output logic          neg_o
);
    logic [DW:0] wide;

    always_comb begin
        if (sub_i) wide = {1'b0, a_i} - {1'b0, b_i};
        else       wide = {1'b0, a_i} + {1'b0, b_i};
        res_o   = wide[DW-1:0];
        carry_o = wide[DW];
        zero_o  = (wide[DW-1:0] == '0);
        neg_o   = wide[DW-1];
    end
endmodule

// File: rtl/acc_status.sv
module acc_status
    import acc_cpu_pkg::*;
#(
    parameter int SENSE_W = 4,
    parameter int FLAG_W  = NFLAG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               upd_c_i,
    input  logic               upd_zn_i,
    input  logic               c_i,
    input  logic               z_i,
    input  logic               n_i,
    input  logic               set_i,
    input  logic               tog_i,
    input  logic [FLAG_W-1:0]  mask_i,
    input  logic [SENSE_W-1:0] sense_i,
    output logic [FLAG_W-1:0]  flags_o,
    output logic [SENSE_W+FLAG_W-1:0] status_o
);
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] flags_d;

    always_comb begin
        flags_d = flags_q;
        if (upd_c_i)  flags_d[F_C] = c_i;
        if (upd_zn_i) begin
            flags_d[F_Z] = z_i;
            flags_d[F_N] = n_i;
        end
        if (set_i) flags_d = flags_d | mask_i;
        if (tog_i) flags_d = flags_d ^ mask_i;
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_d;
    end

    assign flags_o  = flags_q;
    assign status_o = {sense_i, flags_q};

    // R8
    sfl_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (set_i && !tog_i && !upd_c_i && !upd_zn_i)
        |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R8
    tgf_parity_chk: assert property (@(posedge clk) disable iff (rst)
        (tog_i && !set_i && !upd_c_i && !upd_zn_i)
        |=> ((flags_q ^ $past(flags_q)) == $past(mask_i)));
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
#(
    parameter logic [7:0] BOOT_ADDR = 8'hFF,
    parameter int         SENSE_W   = 4,
    parameter int         FLAG_W    = NFLAG
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [SENSE_W-1:0] sense_sw,
    input  logic               wait_n,
    input  logic [7:0]         mem_rdata,
    output logic [7:0]         mem_addr,
    output logic [7:0]         mem_wdata,
    output logic               mem_rd_n,
    output logic               mem_wr_n,
    output logic [7:0]         acc_o,
    output logic [7:0]         pc_o,
    output logic [SENSE_W+FLAG_W-1:0] status_o,
    output logic               halted_o
);
    localparam int STAT_W = SENSE_W + FLAG_W;

    seq_state_t    state_q, state_d;
    logic [AW-1:0] pc_q, pc_d;
    logic [DW-1:0] acc_q, acc_d;
    logic [DW-1:0] ir_q, opd_q, val_q;

    decoded_t      dec;
    logic          needs_ind, is_store;
    logic [DW-1:0] value;
    logic [AW-1:0] pc_seq;

    logic [DW-1:0] alu_res;
    logic          alu_c, alu_z, alu_n;
    logic          in_exe;
    logic          upd_c, upd_zn, set_en, tog_en;
    logic          st_z, st_n;
    logic          rd_req, wr_req;
    logic [FLAG_W-1:0] flags;

    acc_decode u_dec (
        .opcode_i    (ir_q),
        .dec_o       (dec),
        .needs_ind_o (needs_ind),
        .is_store_o  (is_store)
    );

    assign value  = needs_ind ? val_q : opd_q;
    assign pc_seq = pc_q + STEP_INSTR;
    assign in_exe = (state_q == ST_EXE);

    acc_addsub u_alu (
        .a_i     (acc_q),
        .b_i     (value),
        .sub_i   (dec.op == OP_SUB),
        .res_o   (alu_res),
        .carry_o (alu_c),
        .zero_o  (alu_z),
        .neg_o   (alu_n)
    );

    // execute-stage datapath
    always_comb begin
        acc_d  = acc_q;
        pc_d   = pc_seq;
        upd_c  = 1'b0;
        upd_zn = 1'b0;
        set_en = 1'b0;
        tog_en = 1'b0;
        st_z   = alu_z;
        st_n   = alu_n;
        if (dec.kind == K_IMM || dec.kind == K_IND) begin
            unique case (dec.op)
                OP_LDA: begin
                    acc_d  = value;
                    upd_zn = 1'b1;
                    st_z   = (value == '0);
                    st_n   = value[DW-1];
                end
                OP_STA: ;
                OP_ADD, OP_SUB: begin
                    acc_d  = alu_res;
                    upd_c  = 1'b1;
                    upd_zn = 1'b1;
                end
                OP_JMP: pc_d = value;
                OP_SEQ: if (acc_q == value) pc_d = pc_q + STEP_SKIP;
                OP_SFL: set_en = 1'b1;
                OP_TGF: tog_en = 1'b1;
                default: ;
            endcase
        end
    end

    acc_status #(
        .SENSE_W (SENSE_W),
        .FLAG_W  (FLAG_W)
    ) u_stat (
        .clk      (clk),
        .rst      (rst),
        .upd_c_i  (in_exe && upd_c),
        .upd_zn_i (in_exe && upd_zn),
        .c_i      (alu_c),
        .z_i      (st_z),
        .n_i      (st_n),
        .set_i    (in_exe && set_en),
        .tog_i    (in_exe && tog_en),
        .mask_i   (value[FLAG_W-1:0]),
        .sense_i  (sense_sw),
        .flags_o  (flags),
        .status_o (status_o)
    );

    // sequencer next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_VEC:   state_d = wait_n ? ST_FOP : ST_PAUSE;
            ST_FOP:   state_d = ST_FARG;
            ST_FARG:  state_d = needs_ind ? ST_IND : ST_EXE;
            ST_IND:   state_d = ST_EXE;
            ST_EXE: begin
                if (dec.kind == K_HALT) state_d = ST_HALT;
                else if (!wait_n)       state_d = ST_PAUSE;
                else                    state_d = ST_FOP;
            end
            ST_PAUSE: if (wait_n) state_d = ST_FOP;
            ST_HALT:  state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // memory port
    always_comb begin
        unique case (state_q)
            ST_VEC:  mem_addr = BOOT_ADDR;
            ST_FOP:  mem_addr = pc_q;
            ST_FARG: mem_addr = pc_q + AW'(1);
            ST_IND:  mem_addr = opd_q;
            ST_EXE:  mem_addr = value;
            default: mem_addr = pc_q;
        endcase
        rd_req = (state_q == ST_VEC) || (state_q == ST_FOP)
              || (state_q == ST_FARG) || (state_q == ST_IND);
        wr_req = in_exe && is_store;
    end

    assign mem_rd_n  = !(rd_req && !rst);
    assign mem_wr_n  = !(wr_req && !rst);
    assign mem_wdata = acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_VEC;
            pc_q    <= '0;
            acc_q   <= '0;
            ir_q    <= '0;
            opd_q   <= '0;
            val_q   <= '0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                ST_VEC:  pc_q  <= mem_rdata;
                ST_FOP:  ir_q  <= mem_rdata;
                ST_FARG: opd_q <= mem_rdata;
                ST_IND:  val_q <= mem_rdata;
                ST_EXE: begin
                    acc_q <= acc_d;
                    pc_q  <= pc_d;
                end
                default: ;
            endcase
        end
    end

    assign acc_o    = acc_q;
    assign pc_o     = pc_q;
    assign halted_o = (state_q == ST_HALT);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n));

    // R5
    wr_single_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_wr_n |=> mem_wr_n);

    // R11
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        halted_o |=> (halted_o && mem_rd_n && mem_wr_n));

    // R12
    pause_nofetch_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PAUSE && !wait_n) |=> (mem_rd_n && mem_wr_n));

    // R2
    pc_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc_q) |-> ($past(state_q) == ST_VEC || $past(state_q) == ST_EXE));

    // R9
    sense_view_chk: assert property (@(posedge clk) disable iff (rst)
        status_o[STAT_W-1:FLAG_W] == sense_sw);
endmodule

// File: tb/sim_acc_cpu_core.sv
module sim_acc_cpu_core;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] sense_sw = 4'b1010;
    logic       wait_n = 1'b1;
    logic [7:0] mem_rdata;
    logic [7:0] mem_addr, mem_wdata, acc_o, pc_o, status_o;
    logic       mem_rd_n, mem_wr_n, halted_o;

    logic [7:0] mem [256];
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    acc_cpu_core u0 (
        .clk(clk), .rst(rst), .sense_sw(sense_sw), .wait_n(wait_n),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .acc_o(acc_o),
        .pc_o(pc_o), .status_o(status_o), .halted_o(halted_o)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (!mem_wr_n) mem[mem_addr] <= mem_wdata;

    // fields: addr, opcode, operand, expA, expPC, expFlags, requirement index
    localparam int NV = 21;
    localparam logic [47:0] PROG [NV] = '{
        {8'h10, 8'h50, 8'h7F, 8'h7F, 8'h12, 4'h0, 4'd3},
        {8'h12, 8'h52, 8'h01, 8'h80, 8'h14, 4'h4, 4'd4},
        {8'h14, 8'h52, 8'h80, 8'h00, 8'h16, 4'h3, 4'd4},
        {8'h16, 8'h60, 8'h80, 8'h05, 8'h18, 4'h1, 4'd3},
        {8'h18, 8'h53, 8'h06, 8'hFF, 8'h1A, 4'h5, 4'd4},
        {8'h1A, 8'h63, 8'h84, 8'h04, 8'h1C, 4'h0, 4'd4},
        {8'h1C, 8'h51, 8'h90, 8'h04, 8'h1E, 4'h0, 4'd5},
        {8'h1E, 8'h61, 8'h81, 8'h04, 8'h20, 4'h0, 4'd5},
        {8'h20, 8'h55, 8'h04, 8'h04, 8'h24, 4'h0, 4'd7},
        {8'h24, 8'h55, 8'h05, 8'h04, 8'h26, 4'h0, 4'd7},
        {8'h26, 8'h56, 8'h08, 8'h04, 8'h28, 4'h8, 4'd8},
        {8'h28, 8'h66, 8'h83, 8'h04, 8'h2A, 4'hA, 4'd8},
        {8'h2A, 8'h57, 8'h0A, 8'h04, 8'h2C, 4'h0, 4'd8},
        {8'h2C, 8'h56, 8'h80, 8'h04, 8'h2E, 4'h0, 4'd9},
        {8'h2E, 8'h57, 8'hF1, 8'h04, 8'h30, 4'h1, 4'd8},
        {8'h30, 8'h00, 8'h00, 8'h04, 8'h32, 4'h1, 4'd10},
        {8'h32, 8'h5C, 8'h11, 8'h04, 8'h34, 4'h1, 4'd10},
        {8'h34, 8'h54, 8'h40, 8'h04, 8'h40, 4'h1, 4'd6},
        {8'h40, 8'h64, 8'h82, 8'h04, 8'h50, 4'h1, 4'd6},
        {8'h50, 8'h62, 8'h80, 8'h09, 8'h52, 4'h0, 4'd4},
        {8'h52, 8'h01, 8'h00, 8'h09, 8'h54, 4'h0, 4'd11}
    };

    function automatic string req_tag(input logic [3:0] k);
        case (k)
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            4'd10:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        for (int i = 0; i < NV; i++) begin
            mem[PROG[i][47:40]]        = PROG[i][39:32];
            mem[PROG[i][47:40] + 8'd1] = PROG[i][31:24];
        end
        mem[8'h22] = 8'h50;  // skipped LDA #0
        mem[8'h23] = 8'h00;
        mem[8'h80] = 8'h05;
        mem[8'h81] = 8'h91;
        mem[8'h82] = 8'h50;
        mem[8'h83] = 8'h02;
        mem[8'h84] = 8'hFB;
        mem[8'hFF] = 8'h10;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "rd_n in reset", mem_rd_n, 1);
        check("R1", "wr_n in reset", mem_wr_n, 1);
        check("R1", "A in reset", acc_o, 0);
        check("R1", "PC in reset", pc_o, 0);
        check("R1", "flags in reset", status_o[3:0], 0);
        check("R1", "halted in reset", halted_o, 0);
        rst = 1'b0;
        #1;
        check("R1", "vector read strobe", mem_rd_n, 0);
        check("R1", "vector address", mem_addr, 8'hFF);
        @(posedge clk);
        @(negedge clk);
        check("R1", "PC from vector", pc_o, 8'h10);
        check("R2", "opcode fetch address", mem_addr, 8'h10);
        check("R2", "opcode fetch strobe", mem_rd_n, 0);

        for (int i = 0; i < NV; i++) begin
            automatic logic [7:0] op = PROG[i][39:32];
            automatic int ncyc = (op[7:4] == 4'h6 && !op[3]) ? 4 : 3;
            automatic string tg = req_tag(PROG[i][3:0]);
            repeat (ncyc) @(posedge clk);
            @(negedge clk);
            check(tg, $sformatf("A after step %0d", i), acc_o, PROG[i][23:16]);
            check(tg, $sformatf("PC after step %0d", i), pc_o, PROG[i][15:8]);
            check(tg, $sformatf("flags after step %0d", i), status_o[3:0], PROG[i][7:4]);
        end

        check("R5", "immediate store target", mem[8'h90], 8'h04);
        check("R5", "indirect store target", mem[8'h91], 8'h04);
        check("R10", "no stray write at 0x00", mem[8'h00], 8'h00);
        check("R9", "sense nibble", status_o[7:4], 4'hA);
        check("R11", "halted raised", halted_o, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R11", "no read after halt", mem_rd_n, 1);
        end
        check("R11", "PC frozen after halt", pc_o, 8'h54);

        // R12 wait at boundary
        rst = 1'b1;
        wait_n = 1'b0;
        sense_sw = 4'b0101;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R12", "PC after vector read", pc_o, 8'h10);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R12", "no fetch while waiting", mem_rd_n, 1);
        end
        check("R12", "A cleared by reset", acc_o, 0);
        check("R9", "sense nibble follows pins", status_o[7:4], 4'h5);
        wait_n = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check("R12", "A after resume", acc_o, 8'h7F);
        check("R12", "PC after resume", pc_o, 8'h12);
        wait_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12", "instruction finishes under wait", acc_o, 8'h80);
        check("R12", "PC after finished instruction", pc_o, 8'h14);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R12", "paused after instruction", mem_rd_n, 1);
        end
        check("R12", "PC held while paused", pc_o, 8'h14);

        done = 1'b1;
        finish_run();
    end
endmodule